// File: doc/BRIEF.md
# Flash Parameter Page Checker

This block watches the parameter page of a raw NAND flash device as it is read out, one byte per valid cycle, beginning with byte 0. While the bytes go by it confirms the four-byte identifier at the head of the page. It also runs a CRC-16 over the covered region and picks out two decode bytes: the address-cycle code and the supported timing-mode bit field.

When the final byte (index 255) is taken, the block raises a sticky done flag and reports four results. These are a pass/fail verdict, the fastest timing mode the device offers, a flag that asks for extended-data-out read timing, and a code for the column/row address layout. A start pulse clears the results and rearms the byte counter, so a controller can read the page again or read another device. There is no backpressure: the producer drives a byte and a valid strobe, and bytes past the end of the page are dropped.

Top module: `param_page_checker`

## Requirements
- R1: After reset, done, pass, edo_en, mode and addr_layout are all 0, and the byte counter is armed at byte 0.
- R2: Bytes 0, 1, 2 and 3 must be 0x4F, 0x4E, 0x46 and 0x49 in that order. A mismatch in any one of them gives pass = 0 even when the CRC matches.
- R3: The CRC register starts at 0x4F4E. Bytes 0 to 253 are folded in ascending order: each byte is XORed into bits 15:8, then shifted MSB first through 8 steps with polynomial 0x8005. No final XOR and no reflection are applied. The result must equal byte 254 | (byte 255 << 8), otherwise pass = 0.
- R4: done goes high, and pass, mode, edo_en and addr_layout take their new values, on the clock edge that accepts byte 255 and not earlier.
- R5: mode is the highest n from 5 down to 1 for which bit n of byte 129 is set. If none of bits 5..1 is set, mode is 0. Bits 0, 6 and 7 do not matter.
- R6: edo_en is 1 exactly when the reported mode is 4 or 5.
- R7: addr_layout is decoded from byte 101: 0x22→1 (2 col + 2 row), 0x21→2 (2+1), 0x13→3 (1+3), 0x12→4 (1+2), 0x11→5 (1+1). Code 0x23 and every other value give 0 (2 col + 3 row).
- R8: A start pulse clears done, pass, mode, edo_en and addr_layout on the next edge and restarts the page at byte 0. A byte offered in the same cycle as start is ignored.
- R9: After byte 255, further valid bytes are ignored, and all outputs hold until the next start.
- R10: Cycles with in_valid low neither advance the byte index nor affect any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clear results and restart at byte 0 |
| in_valid | input | 1 | in_byte carries the next page byte |
| in_byte | input | 8 | Page byte |
| done | output | 1 | Page fully received; results valid |
| pass | output | 1 | Identifier and CRC both correct |
| mode | output | 3 | Selected timing mode, 0 to 5 |
| edo_en | output | 1 | Extended-data-out timing requested |
| addr_layout | output | 3 | Address layout code per R7 |

## Verification
The hardest case to reach from the ports is a page whose CRC is correct but whose identifier is wrong. Random bytes almost never give a matching CRC, so the bench builds each page in full, corrupts one identifier byte, and then recomputes the trailing CRC so that only the identifier check can fail. The same build-then-seal approach covers a CRC that is off by one bit in either trailing byte, and pages with random idle gaps and garbage on the data lines while in_valid is low. A start that arrives mid-page or together with a valid byte is also driven, and the bench then confirms that a following clean page still passes.

// File: rtl/param_page_checker.sv
module param_page_checker #(
  parameter int          PAGE_BYTES = 256,
  parameter int          ADDR_IDX   = 101,
  parameter int          TMODE_IDX  = 129,
  parameter logic [15:0] CRC_SEED   = 16'h4F4E,
  parameter logic [15:0] CRC_POLY   = 16'h8005
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       done,
  output logic       pass,
  output logic [2:0] mode,
  output logic       edo_en,
  output logic [2:0] addr_layout
);
  localparam int CNT_W   = $clog2(PAGE_BYTES) + 1;
  localparam int CRC_END = PAGE_BYTES - 3;
  localparam int LO_IDX  = PAGE_BYTES - 2;
  localparam int HI_IDX  = PAGE_BYTES - 1;

  logic [CNT_W-1:0] cnt;
  logic [15:0]      crc, crc_nxt;
  logic [7:0]       crc_lo, addr_code, tmode_bits, sig_exp;
  logic             sig_ok, take;
  logic [2:0]       sel_mode, sel_layout;

  assign take = in_valid && (cnt < CNT_W'(PAGE_BYTES));

  always_comb begin
    crc_nxt = crc ^ {in_byte, 8'h00};
    for (int b = 0; b < 8; b++)
      crc_nxt = crc_nxt[15] ? ((crc_nxt << 1) ^ CRC_POLY) : (crc_nxt << 1);
  end

  always_comb begin
    case (cnt[1:0])
      2'd0:    sig_exp = 8'h4F;
      2'd1:    sig_exp = 8'h4E;
      2'd2:    sig_exp = 8'h46;
      default: sig_exp = 8'h49;
    endcase
  end

  always_comb begin
    if      (tmode_bits[5]) sel_mode = 3'd5;
    else if (tmode_bits[4]) sel_mode = 3'd4;
    else if (tmode_bits[3]) sel_mode = 3'd3;
    else if (tmode_bits[2]) sel_mode = 3'd2;
    else if (tmode_bits[1]) sel_mode = 3'd1;
    else                    sel_mode = 3'd0;
  end

  always_comb begin
    case (addr_code)
      8'h22:   sel_layout = 3'd1;
      8'h21:   sel_layout = 3'd2;
      8'h13:   sel_layout = 3'd3;
      8'h12:   sel_layout = 3'd4;
      8'h11:   sel_layout = 3'd5;
      default: sel_layout = 3'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      cnt         <= '0;
      crc         <= CRC_SEED;
      sig_ok      <= 1'b1;
      crc_lo      <= 8'h00;
      addr_code   <= 8'h00;
      tmode_bits  <= 8'h00;
      done        <= 1'b0;
      pass        <= 1'b0;
      mode        <= 3'd0;
      edo_en      <= 1'b0;
      addr_layout <= 3'd0;
    end else if (take) begin
      cnt <= cnt + 1'b1;
      if (cnt <= CNT_W'(CRC_END)) crc <= crc_nxt;
      if (cnt < CNT_W'(4) && in_byte != sig_exp) sig_ok <= 1'b0;
      if (cnt == CNT_W'(ADDR_IDX))  addr_code  <= in_byte;
      if (cnt == CNT_W'(TMODE_IDX)) tmode_bits <= in_byte;
      if (cnt == CNT_W'(LO_IDX))    crc_lo     <= in_byte;
      if (cnt == CNT_W'(HI_IDX)) begin
        done        <= 1'b1;
        pass        <= sig_ok && (crc == {in_byte, crc_lo});
        mode        <= sel_mode;
        edo_en      <= (sel_mode >= 3'd4);
        addr_layout <= sel_layout;
      end
    end
  end
endmodule

module param_page_checker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       done,
  input logic       pass,
  input logic [2:0] mode,
  input logic       edo_en,
  input logic [2:0] addr_layout
);
  // R8
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !pass && !edo_en && mode == 3'd0 && addr_layout == 3'd0));
  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(mode) && $stable(edo_en) && $stable(addr_layout)));
  // R4
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);
  // R6
  edo_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edo_en |-> (mode == 3'd4 || mode == 3'd5));
  // R5
  mode_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd5);
  // R7
  layout_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_layout <= 3'd5);
endmodule

bind param_page_checker param_page_checker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass),
  .mode(mode), .edo_en(edo_en), .addr_layout(addr_layout)
);

// File: tb/param_page_checker_test.sv
module param_page_checker_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       done, pass, edo_en;
  logic [2:0] mode, addr_layout;

  int total = 0;
  int bad = 0;
  logic [7:0] pg [256];

  always #2 clk = ~clk;

  param_page_checker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_byte(in_byte),
    .done(done), .pass(pass), .mode(mode), .edo_en(edo_en), .addr_layout(addr_layout)
  );

  function automatic logic [15:0] ref_crc();
    logic [15:0] c = 16'h4F4E;
    for (int i = 0; i < 254; i++) begin
      c ^= {pg[i], 8'h00};
      for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
    end
    return c;
  endfunction

  function automatic int ref_mode(logic [7:0] t);
    for (int m = 5; m >= 1; m--) if (t[m]) return m;
    return 0;
  endfunction

  function automatic int ref_layout(logic [7:0] a);
    case (a)
      8'h22: return 1;
      8'h21: return 2;
      8'h13: return 3;
      8'h12: return 4;
      8'h11: return 5;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic seal();
    logic [15:0] c = ref_crc();
    pg[254] = c[7:0];
    pg[255] = c[15:8];
  endtask

  task automatic build(logic [7:0] acode, logic [7:0] tbits);
    for (int i = 4; i < 254; i++) pg[i] = 8'($urandom);
    pg[0] = 8'h4F; pg[1] = 8'h4E; pg[2] = 8'h46; pg[3] = 8'h49;
    pg[101] = acode;
    pg[129] = tbits;
    seal();
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic stream(bit gaps);
    for (int i = 0; i < 256; i++) begin
      if (gaps) begin
        int g = int'($urandom % 3);
        for (int k = 0; k < g; k++) begin
          in_valid = 1'b0; in_byte = 8'($urandom);
          @(negedge clk);
        end
      end
      // R4: nothing reported before the last byte
      if (i == 255) chk("R4 done before last byte", done, 0);
      in_valid = 1'b1; in_byte = pg[i];
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic verify(string what, bit exp_pass);
    chk({"R4 done ", what}, done, 1);
    chk({"R3 pass ", what}, pass, exp_pass);
    chk({"R5 mode ", what}, mode, ref_mode(pg[129]));
    chk({"R6 edo ", what}, edo_en, ref_mode(pg[129]) >= 4);
    chk({"R7 layout ", what}, addr_layout, ref_layout(pg[101]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] codes [8] = '{8'h22, 8'h21, 8'h13, 8'h12, 8'h11, 8'h23, 8'h00, 8'hA7};
    logic [7:0] tmodes [7] = '{8'h00, 8'h01, 8'h03, 8'h0F, 8'h1F, 8'h3F, 8'hC5};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 done", done, 0); chk("R1 pass", pass, 0); chk("R1 mode", mode, 0);
    chk("R1 edo", edo_en, 0); chk("R1 layout", addr_layout, 0);

    // R1: stream right after reset without a start
    build(8'h23, 8'h07);
    stream(1'b0);
    verify("after reset", 1'b1);

    // R7 / R5 / R6 directed sweep
    foreach (codes[c]) begin
      build(codes[c], tmodes[c % 7]);
      pulse_start();
      stream(1'b0);
      verify("R7 sweep", 1'b1);
    end
    foreach (tmodes[t]) begin
      build(8'h22, tmodes[t]);
      pulse_start();
      stream(1'b0);
      verify("R5 sweep", 1'b1);
    end

    // R10: random pages with idle gaps and noise
    for (int n = 0; n < 6; n++) begin
      build(codes[$urandom % 8], 8'($urandom));
      pulse_start();
      stream(1'b1);
      verify("R10 gaps", 1'b1);
    end

    // R2: each identifier byte wrong, CRC resealed
    for (int p = 0; p < 4; p++) begin
      build(8'h21, 8'h1F);
      pg[p] = pg[p] ^ 8'h20;
      seal();
      pulse_start();
      stream(1'b0);
      chk("R2 bad identifier pass", pass, 0);
      chk("R2 bad identifier done", done, 1);
    end

    // R3: CRC byte wrong, low then high
    for (int h = 0; h < 2; h++) begin
      build(8'h12, 8'h3F);
      pg[254 + h] = pg[254 + h] ^ 8'h01;
      pulse_start();
      stream(1'b0);
      chk("R3 bad crc pass", pass, 0);
    end
    // R3: swapped CRC byte order must fail
    build(8'h12, 8'h3F);
    if (pg[254] == pg[255]) pg[254] = pg[254] ^ 8'h80;
    else begin logic [7:0] tmp = pg[254]; pg[254] = pg[255]; pg[255] = tmp; end
    pulse_start();
    stream(1'b0);
    chk("R3 swapped crc pass", pass, 0);

    // R9: extra bytes after the page
    build(8'h13, 8'h1F);
    pulse_start();
    stream(1'b0);
    for (int k = 0; k < 6; k++) begin
      in_valid = 1'b1; in_byte = 8'($urandom);
      @(negedge clk);
    end
    in_valid = 1'b0;
    verify("R9 after extra bytes", 1'b1);

    // R8: start clears results
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R8 done cleared", done, 0); chk("R8 pass cleared", pass, 0);
    chk("R8 mode cleared", mode, 0); chk("R8 layout cleared", addr_layout, 0);

    // R8: abort mid-page, then a clean page passes
    for (int k = 0; k < 100; k++) begin
      in_valid = 1'b1; in_byte = 8'($urandom);
      @(negedge clk);
    end
    in_valid = 1'b0;
    build(8'h11, 8'h03);
    pulse_start();
    stream(1'b0);
    verify("R8 restart mid-page", 1'b1);

    // R8: byte offered with start is ignored
    build(8'h22, 8'h1F);
    @(negedge clk); start = 1'b1; in_valid = 1'b1; in_byte = 8'hAA;
    @(negedge clk); start = 1'b0; in_valid = 1'b0;
    stream(1'b0);
    verify("R8 byte with start", 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule